// File: doc/BRIEF.md
# Bus wait-state insertion controller

This block decides how long an external bus cycle lasts. When an access starts, it takes a wait count of 0 to 7 cycles. The count comes from a programmable setting, and each pair of consecutive address areas shares one setting. The block holds the cycle for that many cycles. For some cycles an active-low external wait pin can then stretch the cycle further. This gives longer waits than the internal count allows, or lets each area have its own timing.

The external wait pin only takes effect when a global enable bit is set. Even then it applies only to areas of type SRAM, and to write cycles in areas of type burst ROM. A cold reset clears the enable bit. A hot reset leaves it unchanged but aborts any access in progress. The bus sequencer sees a one-cycle ready pulse at the end of each access, and a busy flag that covers the whole access.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After cold or hot reset, `busy` and `ready` are both 0.
- R2: When the external wait does not apply, `ready` goes high W cycles after the clock edge that samples `start`. W is the internal wait count of the access's pair, so W=0 gives ready in the cycle right after that edge.
- R3: The wait count for area `a` is `wait_cfg[3*(a/2) +: 3]`, so areas 2k and 2k+1 always get the same count.
- R4: The whole range 0 to 7 of the count is honoured, including both ends.
- R5: When the enable bit is 0, `ext_wait_n` has no effect on any access.
- R6: When the external wait applies, `ext_wait_n` passes through a two-flop synchronizer. `ready` comes no earlier than W cycles after the start edge, and not until the synchronized pin reads 1. If the pin rises just after edge k of the access, the latency is max(W, k+2).
- R7: The area type encoding is 00 SRAM, 01 burst ROM, 10 DRAM, 11 other. With the enable set, the external wait applies to SRAM reads and writes and to burst-ROM writes (`wr`=1), and never to burst-ROM reads, DRAM or other.
- R8: `ready` is a one-cycle pulse. `busy` is 1 from the edge that samples `start` until the edge after `ready`.
- R9: A `start` that arrives while `busy` is 1 has no effect. This includes the cycle in which `ready` is high.
- R10: `hot_rst_n`=0 aborts the access in progress and keeps the enable bit. `rst_n`=0 also aborts, and clears the enable bit to 0.
- R11: `en_we`=1 loads `en_d` into the enable bit, except while either reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| hot_rst_n | input | 1 | Synchronous active-low hot reset |
| start | input | 1 | Access-start strobe |
| area | input | 3 | Area number of the access |
| area_type | input | 2 | Area type (00 SRAM, 01 burst ROM, 10 DRAM, 11 other) |
| wr | input | 1 | 1 = write cycle |
| ext_wait_n | input | 1 | Asynchronous active-low external wait request |
| wait_cfg | input | 12 | Packed 3-bit wait counts, one per area pair, pair 0 in the low bits |
| en_we | input | 1 | Load strobe for the enable bit |
| en_d | input | 1 | Value to load into the enable bit |
| ready | output | 1 | One-cycle end-of-access pulse |
| busy | output | 1 | Access in progress |

## Verification
The first pattern sweeps all eight areas with the pin idle and a different count in each pair. This tells the pair indexing apart from per-area indexing, and it exercises counts 0 and 7. Holding the pin low with the enable cleared checks that the pin is ignored. Holding it low with the enable set, then releasing it at cycles that fall before and after the count has run out, checks the max(W, k+2) latency. That latency pins the synchronizer depth. Repeating the held-pin access over each area type and read/write combination separates the gating rule. Further runs check the following:
- A second strobe during an access.
- A hot reset mid-access followed by a held-pin access.
- A cold reset followed by a held-pin access, which shows whether the enable bit was kept or cleared.

// File: rtl/bwc_pkg.sv
// Shared types for the wait-state controller.
package bwc_pkg;
    typedef enum logic [1:0] {
        AT_SRAM  = 2'b00,
        AT_BROM  = 2'b01,
        AT_DRAM  = 2'b10,
        AT_OTHER = 2'b11
    } area_type_e;
endpackage

// File: rtl/bwc_sync.sv
// Two-flop synchronizer for the active-low wait pin.
// Assumes: the pin is asynchronous; resets to the idle (high) level.
module bwc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic sync_n
);
    logic s1_q, s2_q;

    // Shift the pin through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= pin_n;
            s2_q <= s1_q;
        end
    end

    assign sync_n = s2_q;
endmodule

// File: rtl/bwc_policy.sv
// Holds the external-wait enable bit. Selects the wait count of the
// addressed pair and decides whether the external wait applies.
// Assumes: N_AREAS is even and a power of two, at least 4.
module bwc_policy
    import bwc_pkg::*;
#(
    parameter int N_AREAS = 8,
    parameter int WAIT_W  = 3,
    localparam int AREA_W  = $clog2(N_AREAS),
    localparam int N_PAIRS = N_AREAS / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hot_rst_n,
    input  logic                        en_we,
    input  logic                        en_d,
    input  logic [AREA_W-1:0]           area,
    input  logic [1:0]                  area_type,
    input  logic                        wr,
    input  logic [N_PAIRS*WAIT_W-1:0]   wait_cfg,
    output logic [WAIT_W-1:0]           wait_sel,
    output logic                        use_ext,
    output logic                        en_q
);
    logic [WAIT_W-1:0] pair_wait [N_PAIRS];
    area_type_e        typ;

    // Split the packed configuration into one count per pair.
    for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
        assign pair_wait[g] = wait_cfg[g*WAIT_W +: WAIT_W];
    end

    // Enable bit: cleared by cold reset, kept through hot reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (hot_rst_n && en_we)
            en_q <= en_d;
    end

    // Pick the pair count and apply the type and direction gating.
    always_comb begin
        typ      = area_type_e'(area_type);
        wait_sel = pair_wait[area[AREA_W-1:1]];
        use_ext  = en_q && ((typ == AT_SRAM) || (typ == AT_BROM && wr));
    end
endmodule

// File: rtl/bwc_seq.sv
// Access sequencer. Loads the count on start, counts it down, then
// waits for the synchronized pin when the external wait applies.
// Assumes: start is ignored while busy.
module bwc_seq #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_sel,
    input  logic              use_ext,
    input  logic              ext_ok,
    output logic              ready,
    output logic              busy
);
    logic [WAIT_W-1:0] cnt_q;
    logic              ext_q;

    // The access ends once the count is spent and the pin, if used, allows it.
    assign ready = busy && (cnt_q == '0) && (!ext_q || ext_ok);

    // Access state: idle, or counting and holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            ext_q <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= wait_sel;
                ext_q <= use_ext;
            end
        end else if (ready) begin
            busy <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/bus_wait_ctrl.sv
// Bus wait-state insertion controller (top). Each pair of areas has a
// programmable wait count. A gated external wait pin can extend the cycle.
// Assumes: synchronous active-low cold (rst_n) and hot (hot_rst_n) resets.
module bus_wait_ctrl #(
    parameter int N_AREAS = 8,
    parameter int WAIT_W  = 3,
    localparam int AREA_W  = $clog2(N_AREAS),
    localparam int N_PAIRS = N_AREAS / 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hot_rst_n,
    input  logic                      start,
    input  logic [AREA_W-1:0]         area,
    input  logic [1:0]                area_type,
    input  logic                      wr,
    input  logic                      ext_wait_n,
    input  logic [N_PAIRS*WAIT_W-1:0] wait_cfg,
    input  logic                      en_we,
    input  logic                      en_d,
    output logic                      ready,
    output logic                      busy
);
    logic              any_rst_n;
    logic              sync_n;
    logic [WAIT_W-1:0] wait_sel;
    logic              use_ext;
    logic              en_q;

    assign any_rst_n = rst_n & hot_rst_n;

    bwc_sync u_sync (
        .clk    (clk),
        .rst_n  (any_rst_n),
        .pin_n  (ext_wait_n),
        .sync_n (sync_n)
    );

    bwc_policy #(.N_AREAS(N_AREAS), .WAIT_W(WAIT_W)) u_policy (
        .clk       (clk),
        .rst_n     (rst_n),
        .hot_rst_n (hot_rst_n),
        .en_we     (en_we),
        .en_d      (en_d),
        .area      (area),
        .area_type (area_type),
        .wr        (wr),
        .wait_cfg  (wait_cfg),
        .wait_sel  (wait_sel),
        .use_ext   (use_ext),
        .en_q      (en_q)
    );

    bwc_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk      (clk),
        .rst_n    (any_rst_n),
        .start    (start),
        .wait_sel (wait_sel),
        .use_ext  (use_ext),
        .ext_ok   (sync_n),
        .ready    (ready),
        .busy     (busy)
    );
endmodule

// File: rtl/bwc_chk.sv
// Property checker for bus_wait_ctrl, attached by bind.
module bwc_chk (
    input logic clk,
    input logic rst_n,
    input logic hot_rst_n,
    input logic start,
    input logic ready,
    input logic busy,
    input logic en_q
);
    // R8
    ready_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || !hot_rst_n)
        ready |-> busy);
    // R8
    ready_ends_chk: assert property (@(posedge clk) disable iff (!rst_n || !hot_rst_n)
        ready |=> !busy && !ready);
    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || !hot_rst_n)
        (start && !busy) |=> busy);
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !hot_rst_n)
        (busy && !ready) |=> busy);
    // R10
    hot_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_rst_n) |=> $stable(en_q));
endmodule

bind bus_wait_ctrl bwc_chk u_bwc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hot_rst_n (hot_rst_n),
    .start     (start),
    .ready     (ready),
    .busy      (busy),
    .en_q      (en_q)
);

// File: tb/test_bus_wait_ctrl.sv
module test_bus_wait_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, hot_rst_n = 1'b1;
    logic        start = 1'b0, wr = 1'b0, ext_wait_n = 1'b1;
    logic        en_we = 1'b0, en_d = 1'b0;
    logic [2:0]  area = '0;
    logic [1:0]  area_type = 2'b00;
    logic [11:0] wait_cfg = {3'd5, 3'd7, 3'd3, 3'd0};
    logic        ready, busy;

    int vec = 0, bad = 0, cyc = 0, k = 0;
    logic prev_busy = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    bus_wait_ctrl i_bus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .hot_rst_n(hot_rst_n), .start(start),
        .area(area), .area_type(area_type), .wr(wr), .ext_wait_n(ext_wait_n),
        .wait_cfg(wait_cfg), .en_we(en_we), .en_d(en_d),
        .ready(ready), .busy(busy)
    );

    task automatic check(string tag, int act, int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: measure latency from the start edge and compare with the queue.
    always @(negedge clk) begin
        if (busy && !prev_busy) k = 0;
        else if (busy) k++;
        prev_busy = busy;
        if (ready) begin
            if (exp_q.size() == 0) check("R9 unexpected ready", k, -1);
            else check(tag_q.pop_front(), k, exp_q.pop_front());
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            check("watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    // Driver: one access; rel<0 means the pin stays idle.
    task automatic access(input logic [2:0] a, input logic [1:0] t, input logic w,
                          input int rel, input int exp, input string tag);
        if (rel >= 0) begin
            ext_wait_n = 1'b0;
            repeat (3) @(negedge clk);
        end
        area = a; area_type = t; wr = w; start = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        if (rel >= 0) begin
            repeat (rel) @(negedge clk);
            ext_wait_n = 1'b1;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_en(input logic v);
        en_d = v; en_we = 1'b1;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy after reset", busy, 0);
        check("R1 ready after reset", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: sweep all areas, pin idle
        for (int a = 0; a < 8; a++) begin
            int w;
            w = (a < 2) ? 0 : (a < 4) ? 3 : (a < 6) ? 7 : 5;
            access(3'(a), 2'b00, 1'b0, -1, w, "R2 R3 R4 pair count");
        end

        // R5: enable clear, pin held low is ignored
        access(3'd2, 2'b00, 1'b1, 8, 3, "R5 pin ignored");

        // R11 then R6
        set_en(1'b1);
        access(3'd2, 2'b00, 1'b0, 6, 8, "R6 SRAM extended");
        access(3'd4, 2'b00, 1'b1, 2, 7, "R6 count dominates");
        access(3'd0, 2'b00, 1'b0, 0, 2, "R6 sync depth");

        // R7 type and direction gating
        access(3'd2, 2'b01, 1'b1, 6, 8, "R7 burst ROM write");
        access(3'd2, 2'b01, 1'b0, 6, 3, "R7 burst ROM read");
        access(3'd2, 2'b10, 1'b1, 6, 3, "R7 DRAM");
        access(3'd2, 2'b11, 1'b1, 6, 3, "R7 other");

        // R9: extra strobe during an access
        area = 3'd4; area_type = 2'b00; wr = 1'b0; start = 1'b1;
        exp_q.push_back(7); tag_q.push_back("R9 first access");
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        area = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!ready) @(negedge clk);
        start = 1'b1;               // strobe in the ready cycle
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 idle after ignored strobes", busy, 0);
        check("R9 queue drained", exp_q.size(), 0);

        // R10 hot reset aborts and keeps the enable
        area = 3'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        hot_rst_n = 1'b0;
        @(negedge clk);
        check("R10 busy after hot reset", busy, 0);
        check("R1 ready after hot reset", ready, 0);
        hot_rst_n = 1'b1;
        @(negedge clk);
        access(3'd2, 2'b00, 1'b0, 6, 8, "R10 enable kept");

        // R10 cold reset clears the enable
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 busy after cold reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        access(3'd2, 2'b00, 1'b0, 6, 3, "R10 enable cleared");

        // R11 load is blocked during hot reset
        hot_rst_n = 1'b0;
        set_en(1'b1);
        hot_rst_n = 1'b1;
        @(negedge clk);
        access(3'd2, 2'b00, 1'b0, 6, 3, "R11 load blocked in reset");

        check("R8 queue empty at end", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule